// File: doc/BRIEF.md
# Four-Lane Interleaved Vector Memory with Self-Stepping Address Generation

This block is a vector data store made of four single-port memories placed side by side. A word address is split so that its two lowest bits pick one of the four memories and the remaining bits pick a row inside it. A source that produces one sample per cycle, such as a radio front end or a symbol mapper, can fill the store one word at a time. An execution unit can later fetch or store a full row of four words in one cycle, which suits radix-4 transforms.

Two address generators, one for the write side and one for the read side, are each programmed once before a vector operation. After that, each one steps on its own every time its side performs an accepted access. Each generator has three stepping patterns: linear with a programmable stride, bit-reversed over a programmable power-of-two span, and circular over a programmable length.

A switch between the four lanes and the four memories routes traffic in both directions. A single-word access on any lane can reach whichever memory its address selects, and a row access maps lane k to memory k. Reads return one cycle after they are accepted. When the write side and the read side need the same memory in the same cycle, the write is performed and the read is held back and flagged.

Top module: `quad_bank`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is all zero, and both `wr_addr` and `rd_addr` are 0.
- R2: In linear mode (`cfg_mode` = 0), after k accepted accesses the generator address is (base + k·stride) modulo 2^AW.
- R3: In bit-reversed mode (`cfg_mode` = 1), after k accepted accesses the address is base + reverse(k mod 2^L) over L bits. L is `cfg_log2` clamped to the range 4 to AW, and the stride is ignored.
- R4: In circular mode (`cfg_mode` = 2), with stride below length, the address is base + ((k·stride) mod length), so with stride 1 it wraps from base+length−1 back to base.
- R5: A pulse of `cfg_load` programs the generator chosen by `cfg_sel` (0 write, 1 read) and resets its step count to zero, so the next cycle shows the new base address.
- R6: A single-word write (`wr_wide` = 0) takes the data from lane `wr_lane` of `wr_data`. It stores that word in memory `wr_addr[1:0]`, row `wr_addr[AW-1:2]`.
- R7: A row write (`wr_wide` = 1) stores lane k of `wr_data` (bits k·DW upward) into memory k, row `wr_addr[AW-1:2]`, for all four lanes in one cycle.
- R8: A single-word read returns the word at `rd_addr` on lane `rd_lane` one cycle after acceptance, with `rd_valid` high and the other three lanes zero.
- R9: A row read returns memory k, row `rd_addr[AW-1:2]`, on lane k one cycle after acceptance, with `rd_valid` high.
- R10: If the write and read sides touch a common memory in one cycle, the write completes and `rd_stall` is high in that cycle. No data is returned the next cycle and the read generator does not step. Accesses to disjoint memories both proceed.
- R11: While `rd_valid` is low, `rd_data` is all zero.
- R12: A generator does not step in a cycle without an accepted access on its side or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Program one address generator this cycle |
| cfg_sel | input | 1 | Generator to program: 0 write side, 1 read side |
| cfg_mode | input | 2 | Stepping pattern: 0 linear, 1 bit-reversed, 2 circular |
| cfg_base | input | AW | Start address |
| cfg_stride | input | AW | Step size for the linear and circular patterns |
| cfg_len | input | AW+1 | Length of the circular pattern |
| cfg_log2 | input | 4 | Bit count of the bit-reversed pattern |
| wr_en | input | 1 | Write request |
| wr_wide | input | 1 | 1 writes a full row, 0 writes one word |
| wr_lane | input | 2 | Source lane of a single-word write |
| wr_data | input | 4·DW | Four lanes of write data |
| rd_en | input | 1 | Read request |
| rd_wide | input | 1 | 1 reads a full row, 0 reads one word |
| rd_lane | input | 2 | Destination lane of a single-word read |
| rd_stall | output | 1 | Read blocked by a write to a shared memory this cycle |
| rd_valid | output | 1 | `rd_data` holds the result of the read accepted in the previous cycle |
| rd_data | output | 4·DW | Four lanes of read data |
| wr_addr | output | AW | Current write-side generator address |
| rd_addr | output | AW | Current read-side generator address |

## Verification
A corrupted step count or mode field in one of the generators shows on `wr_addr` or `rd_addr` in the very next cycle. So each pattern is checked address by address, across at least one full wrap. A wrong lane or memory choice inside the switch reaches the ports one cycle after the read is accepted. It shows either as a wrong word on the expected lane or as a non-zero word on a lane that should be empty. Data that is written in one shape and read back in the other exposes this. A faulty conflict decision appears in the same cycle on `rd_stall`. One cycle later it shows on `rd_valid`, on `rd_addr`, and on whether the write actually landed.

// File: rtl/quad_bank.sv
module quad_bank #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_sel,
  input  logic [1:0]      cfg_mode,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_stride,
  input  logic [AW:0]     cfg_len,
  input  logic [3:0]      cfg_log2,
  input  logic            wr_en,
  input  logic            wr_wide,
  input  logic [1:0]      wr_lane,
  input  logic [4*DW-1:0] wr_data,
  input  logic            rd_en,
  input  logic            rd_wide,
  input  logic [1:0]      rd_lane,
  output logic            rd_stall,
  output logic            rd_valid,
  output logic [4*DW-1:0] rd_data,
  output logic [AW-1:0]   wr_addr,
  output logic [AW-1:0]   rd_addr
);
  localparam int NL = 4;
  localparam int RW = AW - 2;
  localparam int ROWS = 1 << RW;
  localparam logic [1:0] M_LIN = 2'd0;
  localparam logic [1:0] M_REV = 2'd1;
  localparam logic [1:0] M_CIR = 2'd2;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [2*AW-1:0] gen_addr;
  logic [1:0]      step;
  logic [3:0]      lg_c;
  logic [NL-1:0]   wmask, rmask;
  logic            rd_go;
  logic [DW-1:0]   wr_narrow;
  logic [NL*DW-1:0] rq;
  logic            rv_q, rw_q;
  logic [1:0]      rl_q, rs_q;

  assign wr_addr = gen_addr[AW-1:0];
  assign rd_addr = gen_addr[2*AW-1:AW];

  assign lg_c = (cfg_log2 < 4'd4) ? 4'd4 :
                (cfg_log2 > 4'(AW)) ? 4'(AW) : cfg_log2;

  assign wmask = !wr_en ? '0 : wr_wide ? '1 : NL'(1) << wr_addr[1:0];
  assign rmask = !rd_en ? '0 : rd_wide ? '1 : NL'(1) << rd_addr[1:0];
  assign rd_stall = |(wmask & rmask);
  assign rd_go = rd_en & ~rd_stall;
  assign step = {rd_go, wr_en};

  for (genvar g = 0; g < 2; g++) begin : g_gen
    logic [1:0]    mode_q;
    logic [AW-1:0] base_q, stride_q, off_q, off_nx, mask, eff;
    logic [AW:0]   len_q, sum;
    logic [3:0]    lg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q   <= M_LIN;
        base_q   <= '0;
        stride_q <= AW'(1);
        len_q    <= {1'b1, {AW{1'b0}}};
        lg_q     <= 4'd4;
        off_q    <= '0;
      end else if (cfg_load && (cfg_sel == (g == 1))) begin
        mode_q   <= cfg_mode;
        base_q   <= cfg_base;
        stride_q <= cfg_stride;
        len_q    <= cfg_len;
        lg_q     <= lg_c;
        off_q    <= '0;
      end else if (step[g]) begin
        off_q <= off_nx;
      end
    end

    assign mask = ~({AW{1'b1}} << lg_q);
    assign sum  = {1'b0, off_q} + {1'b0, stride_q};

    always_comb begin
      case (mode_q)
        M_REV:   off_nx = (off_q + 1'b1) & mask;
        M_CIR:   off_nx = (sum >= len_q) ? AW'(sum - len_q) : sum[AW-1:0];
        default: off_nx = off_q + stride_q;
      endcase
    end

    assign eff = (mode_q == M_REV) ? (flip(off_q) >> (AW - int'(lg_q))) : off_q;
    assign gen_addr[g*AW +: AW] = base_q + eff;
  end

  assign wr_narrow = wr_data[wr_lane*DW +: DW];

  for (genvar m = 0; m < NL; m++) begin : g_mem
    logic [DW-1:0] arr [ROWS];
    logic [DW-1:0] q;
    logic [DW-1:0] wd;
    assign wd = wr_wide ? wr_data[m*DW +: DW] : wr_narrow;
    always_ff @(posedge clk) begin
      if (wmask[m]) arr[wr_addr[AW-1:2]] <= wd;
      if (rd_go && rmask[m]) q <= arr[rd_addr[AW-1:2]];
    end
    assign rq[m*DW +: DW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rw_q <= 1'b0;
      rl_q <= '0;
      rs_q <= '0;
    end else begin
      rv_q <= rd_go;
      if (rd_go) begin
        rw_q <= rd_wide;
        rl_q <= rd_lane;
        rs_q <= rd_addr[1:0];
      end
    end
  end

  assign rd_valid = rv_q;

  always_comb begin
    rd_data = '0;
    if (rv_q) begin
      for (int k = 0; k < NL; k++) begin
        if (rw_q) rd_data[k*DW +: DW] = rq[k*DW +: DW];
        else if (rl_q == 2'(k)) rd_data[k*DW +: DW] = rq[rs_q*DW +: DW];
      end
    end
  end
endmodule

module quad_bank_chk #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_load,
  input logic            cfg_sel,
  input logic            wr_en,
  input logic            rd_en,
  input logic            rd_wide,
  input logic [1:0]      rd_lane,
  input logic            rd_stall,
  input logic            rd_valid,
  input logic [4*DW-1:0] rd_data,
  input logic [AW-1:0]   wr_addr,
  input logic [AW-1:0]   rd_addr
);
  logic [3:0] lane_nz;
  always_comb
    for (int k = 0; k < 4; k++) lane_nz[k] = |rd_data[k*DW +: DW];

  // R10
  stall_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (rd_en && wr_en));

  // R10
  stall_holds_raddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stall && !(cfg_load && cfg_sel)) |=> $stable(rd_addr));

  // R12
  idle_holds_waddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(cfg_load && !cfg_sel)) |=> $stable(wr_addr));

  // R12
  idle_holds_raddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !(cfg_load && cfg_sel)) |=> $stable(rd_addr));

  // R8
  accepted_read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_stall) |=> rd_valid);

  // R10
  blocked_read_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !rd_stall) |=> !rd_valid);

  // R11
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  // R8
  narrow_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_stall && !rd_wide) |=>
      ($onehot0(lane_nz) && ((lane_nz & ~(4'b1 << $past(rd_lane))) == 4'b0)));
endmodule

bind quad_bank quad_bank_chk #(.DW(DW), .AW(AW)) chk_i (.*);

// File: tb/quad_bank_tb_top.sv
module quad_bank_tb_top;
  localparam int DW = 32;
  localparam int AW = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_load = 1'b0, cfg_sel = 1'b0;
  logic [1:0]      cfg_mode = '0;
  logic [AW-1:0]   cfg_base = '0, cfg_stride = '0;
  logic [AW:0]     cfg_len = '0;
  logic [3:0]      cfg_log2 = '0;
  logic            wr_en = 1'b0, wr_wide = 1'b0;
  logic [1:0]      wr_lane = '0;
  logic [4*DW-1:0] wr_data = '0;
  logic            rd_en = 1'b0, rd_wide = 1'b0;
  logic [1:0]      rd_lane = '0;
  logic            rd_stall, rd_valid;
  logic [4*DW-1:0] rd_data;
  logic [AW-1:0]   wr_addr, rd_addr;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [1<<AW];

  always #5 clk = ~clk;

  quad_bank #(.DW(DW), .AW(AW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [4*DW-1:0] act, input logic [4*DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] rv(input logic [AW-1:0] v, input int n);
    logic [AW-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  task automatic cfg(input bit sel, input logic [1:0] mode, input int base, input int stride, input int len, input int lg);
    cfg_sel = sel; cfg_mode = mode; cfg_base = AW'(base); cfg_stride = AW'(stride);
    cfg_len = (AW+1)'(len); cfg_log2 = 4'(lg); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wr1(input int lane, input logic [DW-1:0] d);
    mdl[wr_addr] = d;
    wr_en = 1'b1; wr_wide = 1'b0; wr_lane = 2'(lane);
    wr_data = '0; wr_data[lane*DW +: DW] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wrw(input logic [4*DW-1:0] v);
    for (int k = 0; k < 4; k++) mdl[{wr_addr[AW-1:2], 2'(k)}] = v[k*DW +: DW];
    wr_en = 1'b1; wr_wide = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0;
  endtask

  task automatic rd1(input int lane, input string req);
    logic [AW-1:0] a;
    logic [4*DW-1:0] e;
    a = rd_addr;
    rd_en = 1'b1; rd_wide = 1'b0; rd_lane = 2'(lane);
    @(negedge clk);
    rd_en = 1'b0;
    e = '0; e[lane*DW +: DW] = mdl[a];
    chk(rd_valid && rd_data == e, req, rd_data, e);
  endtask

  task automatic rdw(input string req);
    logic [AW-3:0] r;
    logic [4*DW-1:0] e;
    r = rd_addr[AW-1:2];
    for (int k = 0; k < 4; k++) e[k*DW +: DW] = mdl[{r, 2'(k)}];
    rd_en = 1'b1; rd_wide = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rd_wide = 1'b0;
    chk(rd_valid && rd_data == e, req, rd_data, e);
  endtask

  task automatic t_reset;
    chk(rd_valid == 1'b0, "R1 valid", 128'(rd_valid), 0);
    chk(rd_data == '0, "R1 data", rd_data, 0);
    chk(wr_addr == '0 && rd_addr == '0, "R1 addr", {wr_addr, rd_addr}, 0);
  endtask

  task automatic t_linear;
    cfg(0, 2'd0, 5, 3, 0, 4);
    chk(wr_addr == 5, "R5 load", 128'(wr_addr), 5);
    for (int i = 0; i < 8; i++) begin
      wr1(i % 4, 32'hA000 + i);
      chk(wr_addr == AW'(5 + 3*(i+1)), "R2 write side", 128'(wr_addr), 128'(5 + 3*(i+1)));
    end
    cfg(1, 2'd0, 5, 3, 0, 4);
    for (int i = 0; i < 8; i++) begin
      rd1((i+1) % 4, "R8 narrow read");
      chk(rd_addr == AW'(5 + 3*(i+1)), "R2 read side", 128'(rd_addr), 128'(5 + 3*(i+1)));
    end
    cfg(0, 2'd0, 20, 1, 0, 4);
    wr1(0, 32'h1111);
    cfg(0, 2'd0, 20, 1, 0, 4);
    chk(wr_addr == 20, "R5 reload", 128'(wr_addr), 20);
  endtask

  task automatic t_wide;
    cfg(0, 2'd0, 64, 4, 0, 4);
    wrw({32'hB003, 32'hB002, 32'hB001, 32'hB000});
    wrw({32'hB007, 32'hB006, 32'hB005, 32'hB004});
    cfg(1, 2'd0, 64, 1, 0, 4);
    for (int i = 0; i < 8; i++) rd1(0, "R7 row write lane to memory");
    cfg(0, 2'd0, 96, 1, 0, 4);
    for (int i = 0; i < 8; i++) wr1(3, 32'hC000 + i);
    cfg(1, 2'd0, 96, 4, 0, 4);
    rdw("R9 row read after R6 single writes");
    rdw("R9 second row");
  endtask

  task automatic t_bitrev;
    cfg(0, 2'd0, 128, 1, 0, 4);
    for (int i = 0; i < 16; i++) wr1(i % 4, 32'hD000 + i);
    cfg(1, 2'd1, 128, 3, 0, 4);
    for (int k = 0; k < 20; k++) begin
      chk(rd_addr == 128 + rv(AW'(k % 16), 4), "R3 sequence", 128'(rd_addr), 128'(128 + rv(AW'(k % 16), 4)));
      rd1(k % 4, "R3 data order");
    end
    cfg(0, 2'd1, 200, 1, 0, 2);
    wr1(0, 32'hE0);
    chk(wr_addr == 208, "R3 low clamp", 128'(wr_addr), 208);
    cfg(0, 2'd1, 0, 1, 0, 15);
    wr1(0, 32'hE1);
    chk(wr_addr == 512, "R3 high clamp", 128'(wr_addr), 512);
  endtask

  task automatic t_modulo;
    int o;
    cfg(0, 2'd2, 40, 1, 6, 4);
    for (int k = 0; k < 14; k++) begin
      chk(wr_addr == AW'(40 + k % 6), "R4 stride one", 128'(wr_addr), 128'(40 + k % 6));
      wr1(k % 4, 32'hF000 + k);
    end
    cfg(0, 2'd2, 300, 4, 6, 4);
    o = 0;
    for (int k = 0; k < 9; k++) begin
      chk(wr_addr == AW'(300 + o), "R4 stride four", 128'(wr_addr), 128'(300 + o));
      wr1(0, 32'hF100 + k);
      o = (o + 4) % 6;
    end
  endtask

  task automatic t_conflict;
    logic [4*DW-1:0] e;
    cfg(0, 2'd0, 5, 1, 0, 4);
    cfg(1, 2'd0, 64, 4, 0, 4);
    mdl[5] = 32'h5A5A;
    wr_en = 1'b1; wr_wide = 1'b0; wr_lane = 2'd0; wr_data = 128'h5A5A;
    rd_en = 1'b1; rd_wide = 1'b1;
    #1 chk(rd_stall == 1'b1, "R10 stall raised", 128'(rd_stall), 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_valid == 1'b0, "R10 no data", 128'(rd_valid), 0);
    chk(rd_addr == 64, "R10 read addr held", 128'(rd_addr), 64);
    chk(wr_addr == 6, "R10 write proceeds", 128'(wr_addr), 6);
    #1 chk(rd_stall == 1'b0, "R10 stall cleared", 128'(rd_stall), 0);
    for (int k = 0; k < 4; k++) e[k*DW +: DW] = mdl[64 + k];
    @(negedge clk);
    rd_en = 1'b0; rd_wide = 1'b0;
    chk(rd_valid && rd_data == e, "R10 retried read", rd_data, e);
    cfg(1, 2'd0, 5, 1, 0, 4);
    rd1(1, "R10 write landed");
    cfg(1, 2'd0, 65, 1, 0, 4);
    mdl[6] = 32'h6B6B;
    wr_en = 1'b1; wr_wide = 1'b0; wr_lane = 2'd0; wr_data = 128'h6B6B;
    rd_en = 1'b1; rd_lane = 2'd2;
    #1 chk(rd_stall == 1'b0, "R10 disjoint no stall", 128'(rd_stall), 0);
    e = '0; e[2*DW +: DW] = mdl[65];
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid && rd_data == e, "R10 disjoint read", rd_data, e);
    chk(wr_addr == 7, "R10 disjoint write", 128'(wr_addr), 7);
    cfg(1, 2'd0, 6, 1, 0, 4);
    rd1(0, "R10 disjoint write landed");
  endtask

  task automatic t_idle;
    logic [AW-1:0] a, b;
    @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == '0, "R11 zero when idle", rd_data, 0);
    a = wr_addr; b = rd_addr;
    repeat (3) @(negedge clk);
    chk(wr_addr == a && rd_addr == b, "R12 no step while idle", {wr_addr, rd_addr}, {a, b});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_wide();
    t_bitrev();
    t_modulo();
    t_conflict();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule